// File: doc/BRIEF.md
# Low-Bit Image Steganography Embedder

This block hides a serial secret bitstream inside a stream of 8-bit grayscale cover pixels. The message arrives first, one bit per clock. A length counter totals the bits and writes them into an internal bit store. A done strobe closes the message and publishes its length. After that, cover pixels arrive in raster order, one per clock, each qualified by `start`. A capture stage holds each pixel while its message bits are fetched from the store. The next stage rewrites the pixel's low bits, so the block returns one stego pixel per accepted pixel, two clocks later, with a valid strobe.

The number of message bits carried per pixel is chosen at run time, from 1 to 4. It is sampled while the message is still loading. With one bit per pixel the pixel is moved by at most one step: down by one when its LSB is 1 and the bit is 0, up by one in the opposite case. With more bits per pixel the low field is overwritten. Once the whole message has been placed, later pixels leave unchanged. A colour image is handled by three instances, one per channel.

Top module: `stego_embedder`

## Requirements
- R1: While loading, each cycle with `msgValid` high adds one bit to the count, up to the capacity `MAX_BITS` (default 256); bits beyond the capacity are dropped. The cycle after `msgDone` is sampled, `msgLenValid` is high and `msgLen` shows the final count; both then stay fixed until reset.
- R2: The bits-per-pixel value k is taken from `bitsPerPix` only while the message is loading. A value of 0 becomes 1 and values 5 to 7 become 4. Changes made after `msgDone` have no effect on any stego pixel.
- R3: With k=1, a pixel whose LSB already equals its message bit leaves unchanged. LSB 1 with message bit 0 gives pixel−1. LSB 0 with message bit 1 gives pixel+1.
- R4: With k from 2 to 4, pixel bits [k−1:0] are replaced by the next k message bits. The first-received bit goes to bit k−1 and the last goes to bit 0.
- R5: Each cycle with `start` high after `msgLenValid` yields exactly one stego pixel, with `stegoValid` high two clock edges later, in input order. Back-to-back pixels give back-to-back outputs.
- R6: Embedding stops exactly at `msgLen` bits. If fewer than k bits remain, they fill bits k−1 downward and the lower bits of that field stay as in the cover pixel. All later pixels pass through unchanged.
- R7: When `msgDone` is given with no message bits (`msgLen` = 0), every pixel passes through unchanged.
- R8: `start` is ignored while `msgLenValid` is low: no stego pixel is produced for it.
- R9: A stego pixel differs from its cover pixel only in bits [k−1:0].
- R10: An active-low synchronous reset `rstN` clears the pipeline, the count and the length flag. During reset, `stegoValid`, `msgLenValid` and `msgLen` are all 0.
- R11: `msgValid` and `msgBit` are ignored once `msgLenValid` is high; `msgLen` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| bitsPerPix | input | 3 | Requested message bits per pixel (clamped to 1..4) |
| msgBit | input | 1 | Serial message bit |
| msgValid | input | 1 | Qualifies msgBit |
| msgDone | input | 1 | Closes the message; a bit valid in the same cycle is counted |
| msgLen | output | 13 | Counted message length in bits |
| msgLenValid | output | 1 | Length final, embedding enabled |
| start | input | 1 | Qualifies pixelIn |
| pixelIn | input | 8 | Cover pixel, raster order |
| stegoOut | output | 8 | Stego pixel |
| stegoValid | output | 1 | Qualifies stegoOut |

## Verification
The case that needs the most care is the pixel that carries the end of the message. In that one cycle the embed step and the end-of-message pass-through both act on the same pixel. Message lengths that are not a multiple of k (10 bits at k=3, 7 bits at k=2) are used to land a partial group on a single pixel, and the pixels that follow must leave unchanged. A bench reference model with its own bit index predicts every pixel. The ±1 form is used for k=1 and field replacement for larger k. Each output is compared in order as it appears, and each output is also checked to have left every bit above the k-bit field alone.

// File: rtl/stego_pkg.sv
package stego_pkg;
  localparam int LEN_W = 13;   // message length counter width
  localparam int KW    = 3;    // width of a bits-per-pixel value
  localparam int MAXK  = 4;    // largest bits-per-pixel field

  // strobes from control to datapath
  typedef struct packed {
    logic             wrEn;
    logic             wrBit;
    logic [LEN_W-1:0] wrAddr;
    logic             pixCap;
    logic [KW-1:0]    takeN;
    logic [LEN_W-1:0] rdAddr;
    logic [KW-1:0]    kSel;
  } strobe_t;
endpackage

// File: rtl/stego_ctrl.sv
module stego_ctrl
  import stego_pkg::*;
#(
  parameter int MAX_BITS = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [KW-1:0]    bitsPerPix,
  input  logic             msgBit,
  input  logic             msgValid,
  input  logic             msgDone,
  input  logic             start,
  output strobe_t          strb,
  output logic [LEN_W-1:0] msgLen,
  output logic             msgLenValid
);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_BITS);

  logic             loaded;
  logic [LEN_W-1:0] count;
  logic [LEN_W-1:0] used;
  logic [KW-1:0]    kReg;
  logic [KW-1:0]    kClamp;
  logic [LEN_W-1:0] remain;
  logic [KW-1:0]    take;

  always_comb begin
    if (bitsPerPix == '0)                 kClamp = KW'(1);
    else if (bitsPerPix > KW'(MAXK))      kClamp = KW'(MAXK);
    else                                  kClamp = bitsPerPix;

    remain = count - used;
    take   = (remain < LEN_W'(kReg)) ? remain[KW-1:0] : kReg;

    strb.wrEn   = !loaded && msgValid && (count < CAP);
    strb.wrBit  = msgBit;
    strb.wrAddr = count;
    strb.pixCap = loaded && start;
    strb.takeN  = take;
    strb.rdAddr = used;
    strb.kSel   = kReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loaded <= 1'b0;
      count  <= '0;
      used   <= '0;
      kReg   <= KW'(1);
    end else begin
      if (!loaded) kReg <= kClamp;
      if (strb.wrEn) count <= count + LEN_W'(1);
      if (!loaded && msgDone) loaded <= 1'b1;
      if (strb.pixCap) used <= used + LEN_W'(take);
    end
  end

  assign msgLen      = count;
  assign msgLenValid = loaded;
endmodule

// File: rtl/stego_datapath.sv
module stego_datapath
  import stego_pkg::*;
#(
  parameter int MAX_BITS = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic [7:0] pixelIn,
  output logic [7:0] stegoOut,
  output logic       stegoValid
);
  localparam int AW = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
  localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_BITS);

  logic [MAX_BITS-1:0] bitMem;
  logic [MAXK-1:0]     grp;

  // capture stage: cover pixel held while its group is fetched
  logic [7:0]      pixR;
  logic [MAXK-1:0] grpR;
  logic [KW-1:0]   nR;
  logic [KW-1:0]   kR;
  logic            vR;
  logic [7:0]      embedded;

  always_ff @(posedge clk) begin
    if (strb.wrEn) bitMem[strb.wrAddr[AW-1:0]] <= strb.wrBit;
  end

  for (genvar j = 0; j < MAXK; j++) begin : g_fetch
    logic [LEN_W-1:0] addr;
    assign addr   = strb.rdAddr + LEN_W'(j);
    assign grp[j] = (addr < CAP) ? bitMem[addr[AW-1:0]] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixR <= '0;
      grpR <= '0;
      nR   <= '0;
      kR   <= '0;
      vR   <= 1'b0;
    end else begin
      vR <= strb.pixCap;
      if (strb.pixCap) begin
        pixR <= pixelIn;
        grpR <= grp;
        nR   <= strb.takeN;
        kR   <= strb.kSel;
      end
    end
  end

  always_comb begin
    embedded = pixR;
    for (int j = 0; j < MAXK; j++) begin
      if (KW'(j) < nR) embedded[3'(kR - KW'(j) - KW'(1))] = grpR[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stegoOut   <= '0;
      stegoValid <= 1'b0;
    end else begin
      stegoValid <= vR;
      if (vR) stegoOut <= embedded;
    end
  end
endmodule

// File: rtl/stego_embedder.sv
module stego_embedder
  import stego_pkg::*;
#(
  parameter int MAX_BITS = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [KW-1:0]    bitsPerPix,
  input  logic             msgBit,
  input  logic             msgValid,
  input  logic             msgDone,
  output logic [LEN_W-1:0] msgLen,
  output logic             msgLenValid,
  input  logic             start,
  input  logic [7:0]       pixelIn,
  output logic [7:0]       stegoOut,
  output logic             stegoValid
);
  strobe_t strb;

  stego_ctrl #(.MAX_BITS(MAX_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitsPerPix(bitsPerPix), .msgBit(msgBit),
    .msgValid(msgValid), .msgDone(msgDone), .start(start), .strb(strb),
    .msgLen(msgLen), .msgLenValid(msgLenValid)
  );

  stego_datapath #(.MAX_BITS(MAX_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pixelIn(pixelIn),
    .stegoOut(stegoOut), .stegoValid(stegoValid)
  );
endmodule

// File: rtl/stego_embedder_chk.sv
module stego_embedder_chk (
  input logic        clk,
  input logic        rstN,
  input logic [12:0] msgLen,
  input logic        msgLenValid,
  input logic        start,
  input logic [7:0]  pixelIn,
  input logic [7:0]  stegoOut,
  input logic        stegoValid
);
  a_r1_len_frozen: assert property (@(posedge clk) disable iff (!rstN)
    msgLenValid |=> msgLenValid && $stable(msgLen));

  a_r8_out_needs_len: assert property (@(posedge clk) disable iff (!rstN)
    stegoValid |-> msgLenValid);

  a_r5_latency: assert property (@(posedge clk) disable iff (!rstN)
    (start && msgLenValid) |-> ##2 stegoValid);

  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    stegoValid |-> $past(start, 2) && $past(msgLenValid, 2));

  a_r9_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    stegoValid |-> stegoOut[7:4] == $past(pixelIn[7:4], 2));

  a_r7_zero_pass: assert property (@(posedge clk) disable iff (!rstN)
    (stegoValid && msgLen == 13'd0) |-> stegoOut == $past(pixelIn, 2));
endmodule

bind stego_embedder stego_embedder_chk u_chk (
  .clk(clk), .rstN(rstN), .msgLen(msgLen), .msgLenValid(msgLenValid),
  .start(start), .pixelIn(pixelIn), .stegoOut(stegoOut), .stegoValid(stegoValid)
);

// File: tb/test_stego_embedder.sv
module test_stego_embedder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  bitsPerPix = 3'd1;
  logic        msgBit = 1'b0;
  logic        msgValid = 1'b0;
  logic        msgDone = 1'b0;
  logic [12:0] msgLen;
  logic        msgLenValid;
  logic        start = 1'b0;
  logic [7:0]  pixelIn = 8'd0;
  logic [7:0]  stegoOut;
  logic        stegoValid;

  always #5 clk = ~clk;

  stego_embedder i_stego_embedder (
    .clk(clk), .rstN(rstN), .bitsPerPix(bitsPerPix), .msgBit(msgBit),
    .msgValid(msgValid), .msgDone(msgDone), .msgLen(msgLen),
    .msgLenValid(msgLenValid), .start(start), .pixelIn(pixelIn),
    .stegoOut(stegoOut), .stegoValid(stegoValid)
  );

  localparam int CAP = 256;
  int checks = 0;
  int errors = 0;
  int expQ[$];
  int covQ[$];
  int kQ[$];
  string tagQ[$];
  bit tbMsg[0:511];
  int tbLen = 0, tbUsed = 0, tbK = 1;

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && stegoValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected stego pixel", stegoOut, -1);
      end else begin
        int e, c, k;
        string t;
        e = expQ.pop_front(); c = covQ.pop_front();
        k = kQ.pop_front();  t = tagQ.pop_front();
        check(stegoOut == e, t, stegoOut, e);
        check(((stegoOut ^ c) >> k) == 0, "R9 upper bits kept", stegoOut, c);
      end
    end
  end

  function automatic bit pat(int i, int seed);
    return bit'((((i * 7 + seed) >> 2) ^ i ^ seed) & 1);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; start = 0; msgValid = 0; msgDone = 0;
    repeat (2) @(negedge clk);
    check(stegoValid == 0, "R10 stegoValid in reset", stegoValid, 0);
    check(msgLenValid == 0, "R10 msgLenValid in reset", msgLenValid, 0);
    check(msgLen == 0, "R10 msgLen in reset", msgLen, 0);
    expQ.delete(); covQ.delete(); kQ.delete(); tagQ.delete();
    rstN = 1'b1;
  endtask

  task automatic loadMsg(int n, int seed, int kIn, bit useHi);
    int expLen;
    @(negedge clk);
    bitsPerPix = 3'(kIn);
    for (int i = 0; i < n; i++) begin
      bit b;
      b = useHi ? bit'((16'h6869 >> (15 - i)) & 1) : pat(i, seed);
      if (i < 512) tbMsg[i] = b;
      msgValid = 1'b1; msgBit = b; msgDone = (i == n - 1);
      @(negedge clk);
    end
    if (n == 0) begin
      msgDone = 1'b1;
      @(negedge clk);
    end
    msgValid = 0; msgDone = 0;
    expLen = (n > CAP) ? CAP : n;
    check(msgLenValid == 1, "R1 length valid after done", msgLenValid, 1);
    check(msgLen == expLen, "R1 length count", msgLen, expLen);
    tbLen = expLen; tbUsed = 0;
    tbK = (kIn == 0) ? 1 : (kIn > 4) ? 4 : kIn;
  endtask

  // driver: predict, push, then drive for one cycle (held until next call/endPix)
  task automatic sendPix(int p, string tag);
    int e;
    int take;
    e = p;
    take = tbLen - tbUsed;
    if (take > tbK) take = tbK;
    if (take < 0) take = 0;
    if (tbK == 1) begin
      if (take == 1 && (p & 1) != tbMsg[tbUsed]) e = tbMsg[tbUsed] ? p + 1 : p - 1;
    end else begin
      for (int j = 0; j < take; j++) begin
        int pos;
        pos = tbK - 1 - j;
        e = (e & ~(1 << pos)) | (int'(tbMsg[tbUsed + j]) << pos);
      end
    end
    tbUsed += take;
    expQ.push_back(e); covQ.push_back(p); kQ.push_back(tbK); tagQ.push_back(tag);
    start = 1'b1; pixelIn = 8'(p);
    @(negedge clk);
  endtask

  task automatic endPix(string tag);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, tag, expQ.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();

    // R8: start before message closed gives nothing
    @(negedge clk);
    start = 1; pixelIn = 8'd77;
    repeat (3) @(negedge clk);
    start = 0;
    repeat (2) @(negedge clk);
    check(stegoValid == 0, "R8 no output before length", stegoValid, 0);

    // R3 k=1, 16-bit message, then R6 pass-through
    loadMsg(16, 0, 1, 1'b1);
    sendPix(172, "R3 k1"); sendPix(229, "R3 k1"); sendPix(91, "R3 k1");
    sendPix(103, "R3 k1"); sendPix(255, "R3 k1"); sendPix(0, "R3 k1");
    for (int i = 0; i < 14; i++) sendPix((i * 37 + 11) & 255, i < 10 ? "R3 k1" : "R6 pass after len");
    endPix("R5 one output per pixel k1");

    // R2 clamp 0 -> 1, late k change ignored, R11 late bits ignored
    doReset();
    loadMsg(6, 3, 0, 1'b0);
    bitsPerPix = 3'd4;
    msgValid = 1; msgBit = 1;
    @(negedge clk);
    msgValid = 0;
    check(msgLen == 6, "R11 late msgValid ignored", msgLen, 6);
    for (int i = 0; i < 8; i++) sendPix((i * 53 + 5) & 255, "R2 k clamped/frozen at 1");
    endPix("R5 drain R2");

    // R4 k=3 with partial group (10 bits) -> R6
    doReset();
    loadMsg(10, 5, 3, 1'b0);
    bitsPerPix = 3'd1;
    for (int i = 0; i < 6; i++) sendPix((i * 71 + 200) & 255, i < 3 ? "R4 k3" : "R6 partial/pass k3");
    endPix("R5 drain k3");

    // R4 k=2 odd length, R6
    doReset();
    loadMsg(7, 9, 2, 1'b0);
    for (int i = 0; i < 6; i++) sendPix((i * 29 + 97) & 255, "R6 k2 odd length");
    endPix("R5 drain k2");

    // R2 clamp 7 -> 4, R1 overflow capacity, R4 k=4
    doReset();
    loadMsg(300, 1, 7, 1'b0);
    for (int i = 0; i < 66; i++) sendPix((i * 13 + 7) & 255, i < 64 ? "R4 k4 clamp" : "R6 pass after full");
    endPix("R5 drain k4");

    // R7 zero length, and exact two-edge latency R5
    doReset();
    loadMsg(0, 0, 3, 1'b0);
    start = 1; pixelIn = 8'd201;
    expQ.push_back(201); covQ.push_back(201); kQ.push_back(3); tagQ.push_back("R7 zero length");
    @(negedge clk);
    start = 0;
    check(stegoValid == 0, "R5 latency not yet", stegoValid, 0);
    @(negedge clk);
    check(stegoValid == 1, "R5 latency two edges", stegoValid, 1);
    for (int i = 0; i < 5; i++) sendPix((i * 41 + 3) & 255, "R7 zero length");
    endPix("R5 drain zero");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule